// File: doc/BRIEF.md
# DMA request source selector

This block decides which event requests a transfer on one DMA channel. A select register holds a 4-bit source code and a mode bit. With the mode bit clear, the code picks one of sixteen basic sources. Code 0 watches for a falling edge on an external pin. Code 1 is a software trigger. Codes 2 through 15 take single-cycle pulses from peripheral request lines such as timers, serial ports and the converter. With the mode bit set, a few codes are routed to alternate sources instead: two extra serial ports, and either edge of the external pin. Every other code keeps its basic source.

When the chosen source fires, a sticky pending flag is set and presented to the transfer engine. The flag stays set until the engine acknowledges the request or software writes a zero to it. Software writes of one leave the flag unchanged. The external pin is asynchronous, so it passes through a two-flop synchronizer before edge detection.

Top module: `dma_req_select`

## Requirements
- R1: After a synchronous reset, the select register reads 00h (code 0, basic mode), the control register reads 00h, and `pending` is low.
- R2: In basic mode (select bit 6 = 0), for codes 2 to 15 a pulse on `periph_req[code]` in cycle t makes `pending` high after the clock edge that samples it. Pulses on any other line have no effect.
- R3: With code 0, a falling edge on `ext_pin` sets the flag. The pin passes through two synchronizer flops, so a level change sampled at edge k is seen as `pending` high after edge k+2. A rising edge has no effect in basic mode.
- R4: A write to the select register (address 0) sets the flag after that write's edge only when the written byte has bit 7 = 1, bit 6 = 0 and bits 3:0 = 0001. Any other combination raises no request.
- R5: The select register holds the code in bits 3:0 and the mode in bit 6. Bits 7, 5 and 4 always read 0, including the software trigger bit just written as 1.
- R6: In extended mode (bit 6 = 1), code 2 takes `alt_req[0]`, code 3 takes `alt_req[1]`, and code 4 takes either edge of the synchronized pin. The basic lines for these codes are ignored.
- R7: In extended mode, codes 0 and 5 to 15 keep their basic sources, and code 1 has no source at all.
- R8: The control register (address 1) shows the flag in bit 0, and its other bits read 0. Writing it with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag as it was.
- R9: A one-cycle `ack` clears the flag after that edge.
- R10: When a request from the selected source arrives in the same cycle as `ack` or a software clear, the flag is set after that edge.
- R11: Without a clear or an `ack`, the flag stays set across any number of cycles, further requests and select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 select, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 select, 1 control |
| rd_data | output | 8 | Read data (combinational) |
| periph_req | input | 16 | Basic peripheral request pulses, indexed by code |
| alt_req | input | 2 | Alternate serial request pulses for extended mode |
| ext_pin | input | 1 | Asynchronous external request pin |
| ack | input | 1 | Request accepted by the transfer engine |
| pending | output | 1 | Sticky request flag |

## Verification
The hardest situations to reach are the collisions: a new request from the selected source landing in the same cycle as `ack` or a software clear. A related case is a pin edge still inside the synchronizer while the select code or mode is rewritten. Directed phases line up a pulse with `ack` and with a control write in one cycle. A long random phase then mixes sparse pulses, pin toggles, random select writes (software trigger bit included) and acknowledges. In that phase a behavioural model tracks the pin history and the flag each cycle, so such overlaps come up many times.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;

    localparam int unsigned NUM_SRC  = 16;
    localparam int unsigned SEL_W    = $clog2(NUM_SRC);
    localparam int unsigned REG_W    = 8;
    localparam int unsigned NUM_ALT  = 2;
    localparam int unsigned ALT_W    = $clog2(NUM_ALT);
    localparam int unsigned SYNC_LEN = 2;

    // register bit positions
    localparam int unsigned MODE_BIT  = 6;
    localparam int unsigned SWREQ_BIT = 7;
    localparam int unsigned FLAG_BIT  = 0;

    // register addresses
    localparam logic ADDR_SEL = 1'b0;
    localparam logic ADDR_CTL = 1'b1;

    // source codes with a fixed meaning
    localparam logic [SEL_W-1:0] CODE_PIN     = SEL_W'(0);
    localparam logic [SEL_W-1:0] CODE_SW      = SEL_W'(1);
    localparam logic [SEL_W-1:0] CODE_ALT0    = SEL_W'(2);
    localparam logic [SEL_W-1:0] CODE_ALT1    = SEL_W'(3);
    localparam logic [SEL_W-1:0] CODE_PIN_ANY = SEL_W'(4);

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PIN_FALL,
        SRC_PIN_ANY,
        SRC_LINE,
        SRC_ALT
    } src_kind_e;

    typedef struct packed {
        logic             mode;
        logic [SEL_W-1:0] code;
    } sel_cfg_t;

    typedef struct packed {
        src_kind_e        kind;
        logic [SEL_W-1:0] idx;
    } src_route_t;

    // Map a mode/code pair to a request source; software trigger is
    // handled at the register port, so its code routes to nothing here.
    function automatic src_route_t route_of(sel_cfg_t c);
        src_route_t r;
        r.kind = SRC_LINE;
        r.idx  = c.code;
        if (c.code == CODE_PIN) begin
            r.kind = SRC_PIN_FALL;
        end else if (c.code == CODE_SW) begin
            r.kind = SRC_NONE;
        end else if (c.mode) begin
            if (c.code == CODE_ALT0) begin
                r.kind = SRC_ALT;
                r.idx  = SEL_W'(0);
            end else if (c.code == CODE_ALT1) begin
                r.kind = SRC_ALT;
                r.idx  = SEL_W'(1);
            end else if (c.code == CODE_PIN_ANY) begin
                r.kind = SRC_PIN_ANY;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dmasel_pin_sync.sv
module dmasel_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[STAGES-1];
        end
    end

    assign fall = last & ~chain[STAGES-1];
    assign rise = ~last & chain[STAGES-1];
endmodule

// File: rtl/dmasel_src_mux.sv
module dmasel_src_mux
    import dmasel_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned NALT = NUM_ALT
) (
    input  sel_cfg_t        cfg,
    input  logic [NSRC-1:0] line_req,
    input  logic [NALT-1:0] alt_req,
    input  logic            pin_fall,
    input  logic            pin_rise,
    output logic            hit
);
    localparam int unsigned AW = (NALT > 1) ? $clog2(NALT) : 1;

    src_route_t route;

    always_comb begin
        route = route_of(cfg);
        unique case (route.kind)
            SRC_PIN_FALL: hit = pin_fall;
            SRC_PIN_ANY:  hit = pin_fall | pin_rise;
            SRC_LINE:     hit = line_req[route.idx];
            SRC_ALT:      hit = alt_req[route.idx[AW-1:0]];
            default:      hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmasel_flag.sv
module dmasel_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end
endmodule

// File: rtl/dma_req_select.sv
module dma_req_select
    import dmasel_pkg::*;
#(
    parameter int unsigned NSRC  = NUM_SRC,
    parameter int unsigned NALT  = NUM_ALT,
    parameter int unsigned DW    = REG_W,
    parameter int unsigned NSYNC = SYNC_LEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [NSRC-1:0] periph_req,
    input  logic [NALT-1:0] alt_req,
    input  logic            ext_pin,
    input  logic            ack,
    output logic            pending
);
    sel_cfg_t cfg_q;
    logic     wr_sel, wr_ctl;
    logic     sw_fire, line_hit, req_hit, sw_clear, flag_clr;
    logic     pin_fall, pin_rise;

    assign wr_sel = wr_en && (wr_addr == ADDR_SEL);
    assign wr_ctl = wr_en && (wr_addr == ADDR_CTL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_sel) begin
            cfg_q.mode <= wr_data[MODE_BIT];
            cfg_q.code <= wr_data[SEL_W-1:0];
        end
    end

    // software trigger judged on the byte being written
    assign sw_fire = wr_sel && wr_data[SWREQ_BIT] && !wr_data[MODE_BIT]
                     && (wr_data[SEL_W-1:0] == CODE_SW);

    dmasel_pin_sync #(.STAGES(NSYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .fall (pin_fall),
        .rise (pin_rise)
    );

    dmasel_src_mux #(.NSRC(NSRC), .NALT(NALT)) u_mux (
        .cfg      (cfg_q),
        .line_req (periph_req),
        .alt_req  (alt_req),
        .pin_fall (pin_fall),
        .pin_rise (pin_rise),
        .hit      (line_hit)
    );

    assign req_hit  = line_hit | sw_fire;
    assign sw_clear = wr_ctl && !wr_data[FLAG_BIT];
    assign flag_clr = ack | sw_clear;

    dmasel_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (req_hit),
        .clr_req (flag_clr),
        .flag    (pending)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_SEL) begin
            rd_data[SEL_W-1:0] = cfg_q.code;
            rd_data[MODE_BIT]  = cfg_q.mode;
        end else begin
            rd_data[FLAG_BIT]  = pending;
        end
    end
endmodule

// File: rtl/dmasel_checks.sv
module dmasel_checks (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic       ack,
    input logic       req_hit,
    input logic       pending
);
    logic ctl_zero_wr;
    assign ctl_zero_wr = wr_en && wr_addr && !wr_data[0];

    // R2: no request, flag stays low
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !pending && !req_hit |=> !pending);

    // R8: writing one to the flag keeps it
    a_r8_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
        pending && wr_en && wr_addr && wr_data[0] && !ack |=> pending);

    // R9: acknowledge clears
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        pending && ack && !req_hit |=> !pending);

    // R10: new request beats any clear
    a_r10_req_wins: assert property (@(posedge clk) disable iff (rst)
        req_hit |=> pending);

    // R11: flag sticky until cleared
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        pending && !ack && !ctl_zero_wr |=> pending);
endmodule

bind dma_req_select dmasel_checks u_checks (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ack     (ack),
    .req_hit (req_hit),
    .pending (pending)
);

// File: tb/tb_dma_req_select.sv
`timescale 1ns/1ps
module tb_dma_req_select;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] periph_req = '0;
    logic [1:0]  alt_req = '0;
    logic        ext_pin = 1'b1;
    logic        ack = 1'b0;
    logic        pending;

    always #5 clk = ~clk;

    dma_req_select dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .periph_req(periph_req), .alt_req(alt_req), .ext_pin(ext_pin),
        .ack(ack), .pending(pending)
    );

    int    vectors = 0;
    int    misses  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // behavioural reference
    int   m_code = 0;
    bit   m_mode = 0;
    bit   m_flag = 0;
    bit   pin_hist[$];

    initial begin
        for (int i = 0; i < 3; i++) pin_hist.push_back(1'b1);
    end

    always @(posedge clk) begin
        bit fall, rise, hit, clr;
        if (rst) begin
            m_code = 0; m_mode = 0; m_flag = 0;
            pin_hist.delete();
            for (int i = 0; i < 3; i++) pin_hist.push_back(1'b1);
        end else begin
            // pin_hist[1] = value seen by the detector now, [2] = one older
            fall = pin_hist[2] && !pin_hist[1];
            rise = !pin_hist[2] && pin_hist[1];
            hit = 0;
            if (m_code == 0)                    hit = fall;
            else if (m_code == 1)               hit = 0;
            else if (m_mode && m_code == 2)     hit = alt_req[0];
            else if (m_mode && m_code == 3)     hit = alt_req[1];
            else if (m_mode && m_code == 4)     hit = fall || rise;
            else                                hit = periph_req[m_code];
            if (wr_en && !wr_addr && wr_data[7] && !wr_data[6] && wr_data[3:0] == 4'd1)
                hit = 1;
            clr = ack || (wr_en && wr_addr && !wr_data[0]);
            if (hit)      m_flag = 1;
            else if (clr) m_flag = 0;
            if (wr_en && !wr_addr) begin
                m_code = int'(wr_data[3:0]);
                m_mode = wr_data[6];
            end
            pin_hist.push_front(ext_pin);
            void'(pin_hist.pop_back());
        end
    end

    task automatic check();
        logic [7:0] exp_rd;
        exp_rd = rd_addr ? {7'b0, m_flag} : {1'b0, m_mode, 2'b00, 4'(m_code)};
        vectors++;
        if (pending !== m_flag) begin
            misses++;
            $display("FAIL %s pending actual=%0b expected=%0b at %0t", cur_req, pending, m_flag, $time);
        end
        vectors++;
        if (rd_data !== exp_rd) begin
            misses++;
            $display("FAIL %s rd_data[addr %0d] actual=%02h expected=%02h at %0t",
                     cur_req, rd_addr, rd_data, exp_rd, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic pulse_line(input int idx);
        periph_req[idx] = 1'b1;
        tick();
        periph_req = '0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic peek_both();
        rd_addr = 0; tick();
        rd_addr = 1; tick();
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst = 0;
        peek_both();

        // R2: basic mode, right and wrong lines
        cur_req = "R2";
        rd_addr = 1;
        for (int c = 2; c < 16; c++) begin
            wr(0, 8'(c));
            pulse_line((c == 15) ? 2 : c + 1);
            tick();
            pulse_line(c);
            tick();
            do_ack();
        end

        // R3: pin falling edge with code 0, rising ignored
        cur_req = "R3";
        wr(0, 8'h00);
        ext_pin = 0;
        repeat (4) tick();
        do_ack();
        ext_pin = 1;
        repeat (5) tick();

        // R4: software trigger only in basic mode with code 0001
        cur_req = "R4";
        wr(0, 8'h81);
        tick();
        do_ack();
        wr(0, 8'hC1);
        tick();
        wr(0, 8'h82);
        tick();
        wr(0, 8'h01);
        tick();

        // R5: unused and trigger bits read back zero
        cur_req = "R5";
        wr(0, 8'hFF);
        peek_both();
        wr(0, 8'hB5);
        peek_both();

        // R6: extended alternates
        cur_req = "R6";
        rd_addr = 1;
        wr(0, 8'h42);
        pulse_line(2);
        tick();
        alt_req = 2'b10; tick(); alt_req = 0;
        alt_req = 2'b01; tick(); alt_req = 0;
        do_ack();
        wr(0, 8'h43);
        pulse_line(3);
        alt_req = 2'b10; tick(); alt_req = 0;
        do_ack();
        wr(0, 8'h44);
        ext_pin = 0; repeat (4) tick();
        do_ack();
        ext_pin = 1; repeat (4) tick();
        do_ack();

        // R7: fallback codes in extended mode
        cur_req = "R7";
        wr(0, 8'h47);
        pulse_line(7);
        do_ack();
        wr(0, 8'h41);
        pulse_line(1);
        tick();
        wr(0, 8'h40);
        ext_pin = 0; repeat (4) tick();
        do_ack();
        ext_pin = 1; repeat (4) tick();

        // R8: write one keeps, write zero clears
        cur_req = "R8";
        wr(0, 8'h05);
        pulse_line(5);
        wr(1, 8'h01);
        wr(1, 8'hFF);
        tick();
        wr(1, 8'hFE);
        tick();

        // R9: ack clears
        cur_req = "R9";
        pulse_line(5);
        do_ack();
        tick();

        // R10: request in the same cycle as ack or software clear
        cur_req = "R10";
        pulse_line(5);
        ack = 1; periph_req[5] = 1; tick(); ack = 0; periph_req = 0;
        tick();
        wr_en = 1; wr_addr = 1; wr_data = 8'h00; periph_req[5] = 1;
        tick();
        wr_en = 0; periph_req = 0;
        tick();
        do_ack();

        // R11: stickiness under random traffic
        cur_req = "R11";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            rd_addr    = 1'($urandom_range(0, 1));
            periph_req = (r < 20) ? 16'(1 << $urandom_range(0, 15)) : '0;
            alt_req    = (r >= 20 && r < 28) ? 2'($urandom_range(1, 3)) : '0;
            if ($urandom_range(0, 9) == 0) ext_pin = ~ext_pin;
            ack   = ($urandom_range(0, 11) == 0);
            wr_en = ($urandom_range(0, 9) == 0);
            wr_addr = 1'($urandom_range(0, 1));
            wr_data = 8'($urandom_range(0, 255));
            if (wr_en && !wr_addr && $urandom_range(0, 3) == 0) wr_data = 8'h81;
            tick();
        end
        periph_req = 0; alt_req = 0; ack = 0; wr_en = 0;
        tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule